// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages that can be filled all at once from a parallel word, or stepped one place toward the last stage with a serial bit entering the first stage. Its control pins behave like those of a discrete shifter: an active-low load level, two clock pins and a serial input. Because the whole block runs from one fast system clock, each pin is first brought into that domain through a flop synchronizer. Shift edges are then found by comparing the synchronized values from one system cycle to the next.

While the load pin is low, the parallel word is copied into the stages on every system cycle, whatever the clock pins do. While it is high, a rising edge of the effective clock moves the data one stage onward. The effective clock is the OR of the two clock pins, so holding either pin high blocks shifting, and the two pins can swap roles. The last stage comes out both true and inverted. All pins here are plain level signals. There is no data stream with a handshake, so there is no valid/ready pair and no back-pressure. The source of the pins paces the block simply by how it toggles them.

Top module: `piso_shift_reg`

## Requirements
- R1: While `rst_n` is low at a rising `sys_clk` edge, every stage clears to 0, so `q_last` is 0 and `q_last_n` is 1, and the edge history clears to "clock low".
- R2: While the synchronized `load_n_pin` is low, `par_in` is copied into the stages on every system cycle. `par_in[0]` goes to the first stage and `par_in[STAGES-1]` goes to the last stage, which drives `q_last`.
- R3: While the synchronized `load_n_pin` is low, rising edges on the clock pins cause no shift. Only the parallel word is seen.
- R4: With `load_n_pin` high, a 0-to-1 change of the synchronized OR of `clk_a_pin` and `clk_b_pin` shifts every stage by one toward the last stage.
- R5: On each shift, the synchronized `ser_in_pin` enters the first stage. After a load, successive shifts present `par_in[STAGES-1]`, then `par_in[STAGES-2]` and so on down to `par_in[0]` on `q_last`, followed by the serial bits.
- R6: While either clock pin is held high, edges on the other pin cause no shift.
- R7: The two clock pins are interchangeable. A rising edge on either pin, with the other held low, shifts once.
- R8: With `load_n_pin` high and no rising effective-clock edge, all stages keep their values.
- R9: `q_last_n` is always the inverse of `q_last`.
- R10: A change on a control pin shows at the outputs no later than `SYNC_DEPTH`+1 system cycles after the first `sys_clk` edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n_pin | input | 1 | Asynchronous active-low parallel-load level |
| clk_a_pin | input | 1 | Asynchronous clock pin A (acts as an inhibit when held high) |
| clk_b_pin | input | 1 | Asynchronous clock pin B (acts as an inhibit when held high) |
| ser_in_pin | input | 1 | Asynchronous serial data into the first stage |
| par_in | input | STAGES | Parallel word; bit 0 goes to the first stage |
| q_last | output | 1 | Last stage, true |
| q_last_n | output | 1 | Last stage, inverted |

## Verification
The bench builds the block with its defaults: eight stages and a two-flop synchronizer. Eight stages make a full run of shifts show every parallel bit, h down to a, on the true output before the serial bits follow. With two synchronizer flops, each pin change reaches the outputs within four system cycles, so the bench spaces its pin changes that far apart. Random pin sequences then exercise the less obvious cases: an inhibit pin rising from low creates an effective edge of its own, and load release interacts with pins that are already high.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Synchronized control pins, one bundle.
  typedef struct packed {
    logic load_n;
    logic ck_a;
    logic ck_b;
    logic ser;
  } pin_bundle_t;

  localparam int unsigned PIN_W = $bits(pin_bundle_t);

  // Reset value: load inactive, clocks low, serial low.
  localparam pin_bundle_t PIN_IDLE = '{load_n: 1'b1, ck_a: 1'b0, ck_b: 1'b0, ser: 1'b0};
endpackage

// File: rtl/piso_pin_sync.sv
module piso_pin_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[DEPTH-1];
endmodule

// File: rtl/piso_clk_edge.sv
module piso_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_a_s,
  input  logic ck_b_s,
  input  logic load_n_s,
  output logic shift_en
);
  logic eff_now;
  logic eff_prev;

  assign eff_now  = ck_a_s | ck_b_s;
  assign shift_en = load_n_s & eff_now & ~eff_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) eff_prev <= 1'b0;
    else        eff_prev <= eff_now;
  end

  // R6
  inhibit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ck_a_s) && ck_a_s) |-> !shift_en);
  // R6
  inhibit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ck_b_s) && ck_b_s) |-> !shift_en);
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n_s,
  input  logic              shift_en,
  input  logic              ser_s,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] stage_q
);
  localparam int unsigned LAST = STAGES - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)         stage_q <= '0;
    else if (!load_n_s) stage_q <= par_in;
    else if (shift_en)  stage_q <= {stage_q[LAST-1:0], ser_s};
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (stage_q == '0));
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> (stage_q == $past(par_in)));
  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && shift_en) |=> (stage_q == {$past(stage_q[LAST-1:0]), $past(ser_s)}));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && !shift_en) |=> $stable(stage_q));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
  parameter int unsigned STAGES     = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              load_n_pin,
  input  logic              clk_a_pin,
  input  logic              clk_b_pin,
  input  logic              ser_in_pin,
  input  logic [STAGES-1:0] par_in,
  output logic              q_last,
  output logic              q_last_n
);
  import piso_pkg::*;

  pin_bundle_t       pins_raw;
  pin_bundle_t       pins_s;
  logic [PIN_W-1:0]  pins_s_bits;
  logic              shift_en;
  logic [STAGES-1:0] stage_q;

  assign pins_raw = '{load_n: load_n_pin, ck_a: clk_a_pin, ck_b: clk_b_pin, ser: ser_in_pin};

  piso_pin_sync #(
    .WIDTH  (PIN_W),
    .DEPTH  (SYNC_DEPTH),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk    (sys_clk),
    .rst_n  (rst_n),
    .d_async(pins_raw),
    .q_sync (pins_s_bits)
  );

  assign pins_s = pin_bundle_t'(pins_s_bits);

  piso_clk_edge u_edge (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .ck_a_s  (pins_s.ck_a),
    .ck_b_s  (pins_s.ck_b),
    .load_n_s(pins_s.load_n),
    .shift_en(shift_en)
  );

  piso_stages #(
    .STAGES(STAGES)
  ) u_stages (
    .clk     (sys_clk),
    .rst_n   (rst_n),
    .load_n_s(pins_s.load_n),
    .shift_en(shift_en),
    .ser_s   (pins_s.ser),
    .par_in  (par_in),
    .stage_q (stage_q)
  );

  assign q_last   = stage_q[STAGES-1];
  assign q_last_n = ~stage_q[STAGES-1];

  // R3
  load_blocks_shift_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !pins_s.load_n |=> (stage_q == $past(par_in)));
endmodule

// File: tb/piso_shift_reg_test.sv
module piso_shift_reg_test;
  localparam int N = 8;
  localparam int SD = 2;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n_pin = 1'b1, clk_a_pin = 1'b0, clk_b_pin = 1'b0, ser_in_pin = 1'b0;
  logic [N-1:0] par_in = '0;
  logic q_last, q_last_n;

  int tests = 0;
  int fails = 0;

  logic [N-1:0] model;
  logic eff_old;

  always #2.5 sys_clk = ~sys_clk;

  piso_shift_reg #(.STAGES(N), .SYNC_DEPTH(SD)) uut (
    .sys_clk(sys_clk), .rst_n(rst_n), .load_n_pin(load_n_pin),
    .clk_a_pin(clk_a_pin), .clk_b_pin(clk_b_pin), .ser_in_pin(ser_in_pin),
    .par_in(par_in), .q_last(q_last), .q_last_n(q_last_n)
  );

  function automatic logic [N-1:0] next_model(logic [N-1:0] cur, logic ld_n,
      logic rose, logic ser, logic [N-1:0] par);
    if (!ld_n) return par;
    if (rose)  return {cur[N-2:0], ser};
    return cur;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Apply current pin values to the model, wait for the sync latency, check (R10, R9).
  task automatic settle(string tag);
    logic eff_new;
    eff_new = clk_a_pin | clk_b_pin;
    model = next_model(model, load_n_pin, eff_new & ~eff_old, ser_in_pin, par_in);
    eff_old = eff_new;
    repeat (SD + 2) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(tag, q_last, model[N-1]);
    chk("R9", q_last_n, ~q_last);
  endtask

  task automatic pulse_a(string tag);
    @(negedge sys_clk); clk_a_pin = 1'b1; settle(tag);
    @(negedge sys_clk); clk_a_pin = 1'b0; settle(tag);
  endtask

  task automatic pulse_b(string tag);
    @(negedge sys_clk); clk_b_pin = 1'b1; settle(tag);
    @(negedge sys_clk); clk_b_pin = 1'b0; settle(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    void'($urandom(32'd4711));
    model = '0;
    eff_old = 1'b0;
    repeat (4) @(posedge sys_clk);
    @(negedge sys_clk);
    chk("R1", q_last, 1'b0);
    chk("R1", q_last_n, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge sys_clk);

    // R2 / R3: load while clock A toggles
    pat = 8'b1011_0010;
    @(negedge sys_clk); par_in = pat; load_n_pin = 1'b0; settle("R2");
    chk("R2", q_last, pat[N-1]);
    for (int k = 0; k < 3; k++) pulse_a("R3");
    chk("R3", q_last, pat[N-1]);
    @(negedge sys_clk); load_n_pin = 1'b1; settle("R2");

    // R4 / R5: eight shifts show h..a, serial 1s follow
    @(negedge sys_clk); ser_in_pin = 1'b1; settle("R5");
    chk("R5", q_last, pat[N-1]);
    for (int k = N - 2; k >= 0; k--) begin
      pulse_a("R4");
      chk("R5", q_last, pat[k]);
    end
    pulse_b("R7");
    chk("R5", q_last, 1'b1);

    // R6: hold B high, A edges do nothing
    @(negedge sys_clk); par_in = 8'b0101_0101; load_n_pin = 1'b0; settle("R2");
    @(negedge sys_clk); load_n_pin = 1'b1; settle("R8");
    @(negedge sys_clk); clk_b_pin = 1'b1; settle("R7");
    chk("R7", q_last, 1'b1);
    for (int k = 0; k < 3; k++) pulse_a("R6");
    chk("R6", q_last, 1'b1);
    @(negedge sys_clk); clk_b_pin = 1'b0; settle("R8");
    chk("R8", q_last, 1'b1);
    // R6 mirror: hold A high, B edges do nothing
    @(negedge sys_clk); ser_in_pin = 1'b0; clk_a_pin = 1'b1; settle("R7");
    for (int k = 0; k < 3; k++) pulse_b("R6");
    chk("R6", q_last, model[N-1]);
    @(negedge sys_clk); clk_a_pin = 1'b0; settle("R8");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 5);
      @(negedge sys_clk);
      case (op)
        0: load_n_pin = ~load_n_pin;
        1: clk_a_pin = ~clk_a_pin;
        2: clk_b_pin = ~clk_b_pin;
        3: ser_in_pin = $urandom_range(0, 1);
        4: par_in = N'($urandom);
        default: clk_a_pin = ~clk_a_pin;
      endcase
      settle("R4");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule